// File: doc/BRIEF.md
# Indirect Control/Status Register Unit

This block is the host-facing register file of a network controller. The host sees two 16-bit ports on a small word-addressed bus. One port holds a pointer and the other reaches whichever internal register the pointer selects. Four 16-bit registers sit behind the pointer:

- Register 0 is the main control/status word. It mixes event flags that the host clears by writing a one, summary bits that are recomputed after every change, a directly written interrupt enable, and start, init and stop commands with a fixed priority.
- Registers 1 and 2 together give a 32-bit pointer to the initialization block.
- Register 3 is a plain mode word.

The receive and transmit engines report their events on pulse inputs, and those pulses set the matching status flags. The unit drives an interrupt line. It also outputs its run state and emits a one-cycle kick after every data-port write, which tells the transmit engine to rescan its ring.

Top module: `csr_port_unit`

## Requirements
- R1: After reset, register 0 reads 0x0004 (stopped), the pointer is 0, registers 1 to 3 are 0, and the interrupt output is low.
- R2: Bus word offset 0 is the data port and reaches the register the pointer selects. Offset 1 is the pointer port and reads back the pointer zero-extended. Reads of any other offset return 0, and writes to them change nothing.
- R3: A pointer-port write is accepted only when the value is below the register count (4). Any other value leaves the pointer unchanged.
- R4: A data write to register 0 with bit 2 (stop) set makes register 0 exactly 0x0004. Every other written bit, and any event arriving in the same cycle, is discarded.
- R5: In register 0, writing 1 to any of bits 14..8 clears that bit, and writing 0 leaves it unchanged. The bits are: 14 babble, 13 collision error, 12 missed frame, 11 memory error, 10 receive done, 9 transmit done, 8 init done.
- R6: Bit 15 of register 0 is set exactly when any of bits 14..11 is set.
- R7: Bit 7 of register 0 is set exactly when any of bits 14..8 is set.
- R8: Every data write to register 0 without stop copies written bit 6 into the interrupt-enable bit 6.
- R9: A register-0 write with bit 0 (init) set sets bits 0 and 8 and clears bit 2. If bit 0 is clear and bit 1 (start) is set, the write sets bits 1, 5 (receiver on) and 4 (transmitter on) and clears bit 2. Init takes priority over start.
- R10: Register 1 gives bits 15..0 and register 2 gives bits 31..16 of the init-block pointer output. Register 3 drives the mode output. All three read back unchanged through the data port.
- R11: A receive-done pulse sets bit 10, a transmit-done pulse sets bit 9, and error input bits 3..0 set bits 14..11. An event arriving in the same cycle as a write-one clear of its bit leaves the bit set.
- R12: The interrupt output is high exactly when bits 7 and 6 of register 0 are both set.
- R13: A one-cycle kick pulse follows every data-port write by one clock, and the kick is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Bus word offset |
| busWe | input | 1 | Bus write strobe |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Bus read data (combinational) |
| rxDoneIn | input | 1 | Receive-done event pulse |
| txDoneIn | input | 1 | Transmit-done event pulse |
| errEvtIn | input | 4 | Error event pulses, bit 3 maps to status bit 14 |
| statusReg | output | 16 | Register 0 contents |
| initPtr | output | 32 | Init-block pointer from registers 2 and 1 |
| modeReg | output | 16 | Register 3 contents |
| stopped | output | 1 | Stop bit |
| started | output | 1 | Start bit |
| rxOn | output | 1 | Receiver-on bit |
| txOn | output | 1 | Transmitter-on bit |
| irqOut | output | 1 | Interrupt request |
| kickOut | output | 1 | Rescan pulse after a data-port write |

## Verification
A pointer that is corrupt or out of range would show up on the very next pointer-port read, and it would send data-port traffic to the wrong register. The init-pointer or mode outputs reveal that one clock after the write. A wrong register-0 update shows up at the status and interrupt pins one clock after the write or event that caused it. The worst cases are the collisions: a stop write racing an event, init and start written together, and an event racing the write-one clear of its own flag. Each of these is driven in isolation, and the result is compared on the following cycle.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int DATA_W = 16;
  localparam int B_ERR   = 15;
  localparam int B_INTR  = 7;
  localparam int B_IENA  = 6;
  localparam int B_RXON  = 5;
  localparam int B_TXON  = 4;
  localparam int B_STOP  = 2;
  localparam int B_START = 1;
  localparam int B_INIT  = 0;
  localparam int B_RXD   = 10;
  localparam int B_TXD   = 9;
  localparam int B_IDONE = 8;
  localparam logic [DATA_W-1:0] STAT_RESET = 16'h0004;

  typedef struct packed {
    logic ptrWr;
    logic dataWr;
    logic stopWr;
  } csrStrobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 4,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output csrStrobe_t        strobe,
  output logic [PTR_W-1:0]  ptr,
  output logic              kick
);
  logic hitData, hitPtr, ptrOk;

  always_comb begin
    hitData = busWe && (busAddr == ADDR_W'(0));
    hitPtr  = busWe && (busAddr == ADDR_W'(1));
    ptrOk   = (busWdata < DATA_W'(NUM_REGS));
    strobe.ptrWr  = hitPtr && ptrOk;
    strobe.dataWr = hitData;
    strobe.stopWr = hitData && (ptr == PTR_W'(0)) && busWdata[B_STOP];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr  <= '0;
      kick <= 1'b0;
    end else begin
      if (strobe.ptrWr) ptr <= busWdata[PTR_W-1:0];
      kick <= hitData;
    end
  end
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 4,
  parameter int ERR_W    = 4,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic [ERR_W-1:0]  errEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] regFile [NUM_REGS]
);
  localparam logic [DATA_W-1:0] W1C_MASK = 16'h7F00;
  localparam int ERR_LO = B_ERR - ERR_W;

  logic [DATA_W-1:0] statNext;
  logic wr0;

  always_comb begin
    wr0 = strobe.dataWr && (ptr == PTR_W'(0));
    statNext = stat;
    if (wr0) begin
      statNext = statNext & ~(busWdata & W1C_MASK);
      statNext[B_IENA] = busWdata[B_IENA];
      if (busWdata[B_INIT]) begin
        statNext[B_INIT]  = 1'b1;
        statNext[B_IDONE] = 1'b1;
        statNext[B_STOP]  = 1'b0;
      end else if (busWdata[B_START]) begin
        statNext[B_START] = 1'b1;
        statNext[B_RXON]  = 1'b1;
        statNext[B_TXON]  = 1'b1;
        statNext[B_STOP]  = 1'b0;
      end
    end
    if (rxDone) statNext[B_RXD] = 1'b1;
    if (txDone) statNext[B_TXD] = 1'b1;
    statNext[B_ERR-1:ERR_LO] = statNext[B_ERR-1:ERR_LO] | errEvt;
    statNext[B_ERR]  = |statNext[B_ERR-1:ERR_LO];
    statNext[B_INTR] = |statNext[B_ERR-1:B_IDONE];
    if (strobe.stopWr) statNext = STAT_RESET;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stat <= STAT_RESET;
    else       stat <= statNext;
  end

  assign regFile[0] = stat;

  for (genvar g = 1; g < NUM_REGS; g++) begin : gPlain
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strobe.dataWr && (ptr == PTR_W'(g))) q <= busWdata;
    end
    assign regFile[g] = q;
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(0): busRdata = regFile[ptr];
      ADDR_W'(1): busRdata = DATA_W'(ptr);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/csr_port_unit.sv
module csr_port_unit
  import csr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 4,
  parameter int ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              rxDoneIn,
  input  logic              txDoneIn,
  input  logic [ERR_W-1:0]  errEvtIn,
  output logic [15:0]       statusReg,
  output logic [31:0]       initPtr,
  output logic [15:0]       modeReg,
  output logic              stopped,
  output logic              started,
  output logic              rxOn,
  output logic              txOn,
  output logic              irqOut,
  output logic              kickOut
);
  localparam int PTR_W = $clog2(NUM_REGS);

  csrStrobe_t strobe;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  csr_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobe(strobe), .ptr(ptr), .kick(kickOut)
  );

  csr_datapath #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .ERR_W(ERR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptr(ptr), .busAddr(busAddr),
    .busWdata(busWdata), .rxDone(rxDoneIn), .txDone(txDoneIn),
    .errEvt(errEvtIn), .busRdata(busRdata), .stat(statusReg),
    .regFile(regFile)
  );

  assign initPtr = {regFile[2], regFile[1]};
  assign modeReg = regFile[3];
  assign stopped = statusReg[B_STOP];
  assign started = statusReg[B_START];
  assign rxOn    = statusReg[B_RXON];
  assign txOn    = statusReg[B_TXON];
  assign irqOut  = statusReg[B_INTR] & statusReg[B_IENA];
endmodule

// File: rtl/csr_port_unit_chk.sv
module csr_port_unit_chk #(
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [15:0]       busWdata,
  input logic [15:0]       busRdata,
  input logic [15:0]       statusReg,
  input logic              irqOut,
  input logic              kickOut,
  input logic              rxOn,
  input logic              txOn
);
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(1)) |-> (busRdata < 16'(NUM_REGS)));

  assert_stop_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(0) && busRdata == statusReg && busWdata[2]
     && $past(rstN)) |=> (statusReg == 16'h0004 || $past(busRdata != statusReg)));

  assert_err_summary_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[15] == (|statusReg[14:11]));

  assert_intr_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[7] == (|statusReg[14:8]));

  assert_irq_line_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (statusReg[7] && statusReg[6]));

  assert_kick_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(0)) |=> kickOut);

  assert_kick_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == ADDR_W'(0)) |=> !kickOut);

  assert_start_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOn) |-> $rose(txOn));
endmodule

bind csr_port_unit csr_port_unit_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .statusReg(statusReg),
  .irqOut(irqOut), .kickOut(kickOut), .rxOn(rxOn), .txOn(txOn)
);

// File: tb/sim_csr_port_unit.sv
module sim_csr_port_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic rxDoneIn = 1'b0, txDoneIn = 1'b0;
  logic [3:0] errEvtIn = '0;
  logic [15:0] statusReg, modeReg;
  logic [31:0] initPtr;
  logic stopped, started, rxOn, txOn, irqOut, kickOut;

  always #10 clk = ~clk;

  csr_port_unit u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .rxDoneIn(rxDoneIn),
    .txDoneIn(txDoneIn), .errEvtIn(errEvtIn), .statusReg(statusReg),
    .initPtr(initPtr), .modeReg(modeReg), .stopped(stopped),
    .started(started), .rxOn(rxOn), .txOn(txOn), .irqOut(irqOut),
    .kickOut(kickOut)
  );

  typedef struct {
    int sel;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t sbq[$];

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] mStat = 16'h0004;
  logic [1:0]  mPtr = 0;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return {16'h0, statusReg};
      1: return {31'h0, irqOut};
      2: return {31'h0, kickOut};
      3: return {16'h0, busRdata};
      4: return initPtr;
      5: return {16'h0, modeReg};
      6: return {28'h0, stopped, started, rxOn, txOn};
      default: return '0;
    endcase
  endfunction

  task automatic expectVal(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  function automatic logic [15:0] nextStat(logic [15:0] cur, logic wr0,
      logic [15:0] wd, logic rx, logic tx, logic [3:0] er);
    logic [15:0] r;
    r = cur;
    if (wr0 && wd[2]) return 16'h0004;
    if (wr0) begin
      r = r & ~(wd & 16'h7F00);
      r[6] = wd[6];
      if (wd[0]) begin r[0] = 1; r[8] = 1; r[2] = 0; end
      else if (wd[1]) begin r[1] = 1; r[5] = 1; r[4] = 1; r[2] = 0; end
    end
    if (rx) r[10] = 1;
    if (tx) r[9] = 1;
    r[14:11] = r[14:11] | er;
    r[15] = |r[14:11];
    r[7] = |r[14:8];
    return r;
  endfunction

  // one bus cycle; expectations are checked just after the next clock edge
  task automatic cycle(logic we, logic [1:0] a, logic [15:0] d,
      logic rx, logic tx, logic [3:0] er, string tag);
    logic wr0;
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = d;
    rxDoneIn = rx; txDoneIn = tx; errEvtIn = er;
    wr0 = we && a == 0 && mPtr == 0;
    mStat = nextStat(mStat, wr0, d, rx, tx, er);
    if (we && a == 1 && d < 16'd4) mPtr = d[1:0];
    expectVal(0, {16'h0, mStat}, tag);
    expectVal(1, {31'h0, mStat[7] & mStat[6]}, {tag, "/R12"});
    expectVal(2, {31'h0, we && a == 0}, {tag, "/R13"});
    @(negedge clk);
    busWe = 0; rxDoneIn = 0; txDoneIn = 0; errEvtIn = 0;
  endtask

  task automatic readPort(logic [1:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    busWe = 0; busAddr = a;
    expectVal(3, {16'h0, exp}, tag);
    expectVal(2, 32'h0, {tag, "/R13"});
  endtask

  // monitor: compares queued expectations a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sbq.pop_front();
        got = observe(it.sel);
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    readPort(2'd1, 16'h0000, "R1 pointer");
    expectVal(0, 32'h0004, "R1 status");
    expectVal(1, 32'h0, "R1 irq");
    expectVal(4, 32'h0, "R1 initPtr");
    expectVal(5, 32'h0, "R1 mode");
    // R3 pointer range
    cycle(1, 2'd1, 16'd2, 0, 0, 0, "R3 ptr write");
    readPort(2'd1, 16'd2, "R3 ptr accepted");
    cycle(1, 2'd1, 16'd7, 0, 0, 0, "R3 ptr reject");
    readPort(2'd1, 16'd2, "R3 ptr kept");
    cycle(1, 2'd1, 16'h0104, 0, 0, 0, "R3 ptr reject high");
    readPort(2'd1, 16'd2, "R3 ptr kept high");
    // R2 unmapped offsets
    readPort(2'd2, 16'h0, "R2 offset2");
    readPort(2'd3, 16'h0, "R2 offset3");
    cycle(1, 2'd3, 16'hFFFF, 0, 0, 0, "R2 write offset3");
    readPort(2'd1, 16'd2, "R2 ptr after stray write");
    readPort(2'd0, 16'h0, "R2 reg2 after stray write");
    // R10 pointer and mode registers
    cycle(1, 2'd0, 16'hABCD, 0, 0, 0, "R10 reg2");
    cycle(1, 2'd1, 16'd1, 0, 0, 0, "R10 sel1");
    cycle(1, 2'd0, 16'h1234, 0, 0, 0, "R10 reg1");
    cycle(1, 2'd1, 16'd3, 0, 0, 0, "R10 sel3");
    cycle(1, 2'd0, 16'h0005, 0, 0, 0, "R10 reg3");
    expectVal(4, 32'hABCD1234, "R10 initPtr");
    expectVal(5, 32'h0005, "R10 mode");
    readPort(2'd0, 16'h0005, "R10 reg3 readback");
    cycle(1, 2'd1, 16'd1, 0, 0, 0, "R10 sel1b");
    readPort(2'd0, 16'h1234, "R10 reg1 readback");
    // R9 init with interrupt enable, R8, R7
    cycle(1, 2'd1, 16'd0, 0, 0, 0, "R2 sel0");
    cycle(1, 2'd0, 16'h0041, 0, 0, 0, "R9 init");
    expectVal(0, 32'h01C1, "R9 init value");
    expectVal(6, 32'h0, "R9 run state after init");
    readPort(2'd0, 16'h01C1, "R2 status readback");
    cycle(1, 2'd0, 16'h0003, 0, 0, 0, "R9 init beats start");
    expectVal(0, 32'h0181, "R8 enable cleared");
    cycle(1, 2'd0, 16'h0100, 0, 0, 0, "R5 clear init done");
    expectVal(0, 32'h0001, "R7 flag drops");
    cycle(1, 2'd0, 16'h0042, 0, 0, 0, "R9 start");
    expectVal(6, 32'h7, "R9 run state after start");
    // R11 events
    cycle(0, 2'd0, 16'h0, 1, 0, 4'h0, "R11 rx event");
    cycle(0, 2'd0, 16'h0, 0, 0, 4'h4, "R11 err event");
    expectVal(0, 32'hA4F3, "R6 err summary set");
    cycle(1, 2'd0, 16'h2240, 0, 1, 4'h0, "R11 tx beats clear");
    cycle(1, 2'd0, 16'h7E40, 0, 0, 4'h0, "R5 clear all events");
    expectVal(0, 32'h0073, "R5 cleared value");
    cycle(0, 2'd0, 16'h0, 0, 0, 4'h8, "R11 babble event");
    // R4 stop overrides everything
    cycle(1, 2'd0, 16'hFFFF, 1, 1, 4'hF, "R4 stop with events");
    expectVal(0, 32'h0004, "R4 exact stop");
    readPort(2'd2, 16'h0, "R13 idle");
    readPort(2'd0, 16'h0004, "R4 readback");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule